// File: doc/BRIEF.md
# Coded Reference Frequency Divider

This block turns a reference clock into a slower reference pulse train for a phase-locked loop. The division ratio is not programmed as a binary number. A three-bit selection code picks one of eight fixed ratios from a small decode table: 8, 64, 128, 256, 640, 1000, 1024 or 2048. A down-counter of twelve bits counts out each period. At the end of each period it emits one single-cycle pulse, which feeds the reference side of the phase comparator.

The selection code is read only when the counter reloads, at terminal count and during reset. An address change in the middle of a period therefore never shortens or stretches that period. The new ratio takes effect from the next period on. A registered copy of the ratio in force is also driven out, and it updates in the same cycle as the pulse.

Top module: `ref_code_divider`

## Requirements
- R1: While `rst_i` is high (synchronous, active high), `fref_o` is 0 and `ratio_o` takes the table ratio of the `sel_i` value sampled at each clock edge.
- R2: Selection codes 3'b000, 3'b001, 3'b010 and 3'b011 give ratios 8, 64, 128 and 256, as seen on `ratio_o` and in the `fref_o` period.
- R3: Selection codes 3'b100, 3'b101, 3'b110 and 3'b111 give ratios 640, 1000, 1024 and 2048, as seen on `ratio_o` and in the `fref_o` period.
- R4: In steady state, consecutive `fref_o` pulses are exactly ratio clock cycles apart.
- R5: Each `fref_o` pulse is high for exactly one clock cycle.
- R6: The first `fref_o` pulse after reset is released appears on the ratio-th rising edge after release.
- R7: A change of `sel_i` during a period has no effect on that period's length or on `ratio_o` until the period ends.
- R8: `ratio_o` changes to the newly sampled ratio on the same edge that raises `fref_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Ratio selection code (bit 2 most significant) |
| fref_o | output | 1 | Divided reference pulse, one cycle wide |
| ratio_o | output | 12 | Ratio currently in force |

## Verification
The hardest case to reach is a selection change inside a running period. The counter gives no hint that it is partway through a period, and the only evidence that the code was sampled at the wrong moment is a period that is a few cycles off. The stimulus releases reset with one code and counts a known number of cycles. It then switches to a ratio that is much shorter or much longer. The remaining distance to the pulse must add up to the old ratio, and the following period must match the new one. A reset applied mid-period with the code changing under reset covers the reload path from the other side.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;

    localparam int unsigned REF_CODE_W  = 3;
    localparam int unsigned REF_CNT_W   = 12;
    localparam int unsigned REF_ENTRIES = 1 << REF_CODE_W;

    typedef logic [REF_CNT_W-1:0]  ref_ratio_t;
    typedef logic [REF_CODE_W-1:0] ref_code_t;

    // Fixed ratio table; index wraps if a wider code is used.
    function automatic ref_ratio_t ref_ratio_decode(input int unsigned idx);
        ref_ratio_t r;
        case (idx % REF_ENTRIES)
            0:       r = ref_ratio_t'(8);
            1:       r = ref_ratio_t'(64);
            2:       r = ref_ratio_t'(128);
            3:       r = ref_ratio_t'(256);
            4:       r = ref_ratio_t'(640);
            5:       r = ref_ratio_t'(1000);
            6:       r = ref_ratio_t'(1024);
            default: r = ref_ratio_t'(2048);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ref_ratio_rom.sv
module ref_ratio_rom
    import ref_div_pkg::*;
#(
    parameter int unsigned CODE_W = REF_CODE_W,
    parameter int unsigned CNT_W  = REF_CNT_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  ratio_o,
    output logic [CNT_W-1:0]  reload_o
);
    localparam int unsigned ENTRIES = 1 << CODE_W;

    logic [CNT_W-1:0] table_w [ENTRIES];

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_entry
        assign table_w[gi] = CNT_W'(ref_ratio_decode(gi));
    end

    assign ratio_o  = table_w[code_i];
    assign reload_o = ratio_o - CNT_W'(1);

endmodule

// File: rtl/ref_down_counter.sv
module ref_down_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             tc_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i || at_zero) begin
            cnt_q <= reload_i;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign tc_o = at_zero && !rst_i;

endmodule

// File: rtl/ref_pulse_stage.sv
module ref_pulse_stage #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tc_i,
    input  logic [CNT_W-1:0] ratio_i,
    output logic             fref_o,
    output logic [CNT_W-1:0] ratio_o
);
    logic             pulse_q;
    logic [CNT_W-1:0] ratio_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pulse_q <= 1'b0;
            ratio_q <= ratio_i;
        end else begin
            pulse_q <= tc_i;
            if (tc_i) begin
                ratio_q <= ratio_i;
            end
        end
    end

    assign fref_o  = pulse_q;
    assign ratio_o = ratio_q;

endmodule

// File: rtl/ref_code_divider.sv
module ref_code_divider
    import ref_div_pkg::*;
#(
    parameter int unsigned CODE_W = REF_CODE_W,
    parameter int unsigned CNT_W  = REF_CNT_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CODE_W-1:0] sel_i,
    output logic              fref_o,
    output logic [CNT_W-1:0]  ratio_o
);
    logic [CNT_W-1:0] rom_ratio;
    logic [CNT_W-1:0] rom_reload;
    logic             term;

    ref_ratio_rom #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_rom (
        .code_i   (sel_i),
        .ratio_o  (rom_ratio),
        .reload_o (rom_reload)
    );

    ref_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .reload_i (rom_reload),
        .tc_o     (term)
    );

    ref_pulse_stage #(.CNT_W(CNT_W)) u_out (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tc_i    (term),
        .ratio_i (rom_ratio),
        .fref_o  (fref_o),
        .ratio_o (ratio_o)
    );

endmodule

// File: rtl/ref_code_divider_chk.sv
module ref_code_divider_chk #(
    parameter int unsigned CODE_W = 3,
    parameter int unsigned CNT_W  = 12
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [CODE_W-1:0] sel_i,
    input logic              fref_o,
    input logic [CNT_W-1:0]  ratio_o
);
    logic [CNT_W:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)       gap_q <= '0;
        else if (fref_o) gap_q <= (CNT_W+1)'(1);
        else             gap_q <= gap_q + (CNT_W+1)'(1);
    end

    // R1: no pulse while in reset
    p_quiet_in_reset_r1: assert property (@(posedge clk_i) rst_i |=> !fref_o);

    // R5: pulse is a single cycle
    p_single_cycle_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        fref_o |=> !fref_o);

    // R4: pulse spacing equals the ratio that was in force
    p_spacing_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        fref_o |-> (gap_q == {1'b0, $past(ratio_o)}));

    // R7: ratio holds between pulses
    p_ratio_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !fref_o) |-> $stable(ratio_o));

    // R2 / R3: ratio is always a table value
    p_ratio_legal_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (ratio_o inside {CNT_W'(8), CNT_W'(64), CNT_W'(128),
            CNT_W'(256), CNT_W'(640), CNT_W'(1000), CNT_W'(1024), CNT_W'(2048)}));

endmodule

bind ref_code_divider ref_code_divider_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .sel_i   (sel_i),
    .fref_o  (fref_o),
    .ratio_o (ratio_o)
);

// File: tb/test_ref_code_divider.sv
module test_ref_code_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  sel = 3'd0;
    logic        fref;
    logic [11:0] ratio;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ref_code_divider i_ref_code_divider (
        .clk_i   (clk),
        .rst_i   (rst),
        .sel_i   (sel),
        .fref_o  (fref),
        .ratio_o (ratio)
    );

    function automatic int exp_ratio(input int code);
        case (code)
            0: return 8;
            1: return 64;
            2: return 128;
            3: return 256;
            4: return 640;
            5: return 1000;
            6: return 1024;
            default: return 2048;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_to_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (fref !== 1'b1 && n < 5000);
    endtask

    task automatic reset_with(input int code);
        @(negedge clk);
        rst = 1'b1;
        sel = 3'(code);
        repeat (2) @(negedge clk);
        check("R1 fref low in reset", int'(fref), 0);
        check("R1 ratio follows code in reset", int'(ratio), exp_ratio(code));
        rst = 1'b0;
    endtask

    task automatic t_code(input int code);
        int n;
        string tag;
        tag = (code < 4) ? "R2" : "R3";
        reset_with(code);
        count_to_pulse(n);
        check({"R6 first pulse delay ", tag}, n, exp_ratio(code));
        check({"R8 ratio at pulse ", tag}, int'(ratio), exp_ratio(code));
        @(negedge clk);
        check("R5 pulse one cycle", int'(fref), 0);
        count_to_pulse(n);
        check({"R4 period ", tag}, n + 1, exp_ratio(code));
    endtask

    task automatic t_mid_change(input int c0, input int c1, input int delay);
        int m;
        reset_with(c0);
        repeat (delay) @(negedge clk);
        sel = 3'(c1);
        @(negedge clk);
        check("R7 ratio held after mid change", int'(ratio), exp_ratio(c0));
        count_to_pulse(m);
        check("R7 period unaffected by mid change", delay + 1 + m, exp_ratio(c0));
        check("R8 new ratio on pulse edge", int'(ratio), exp_ratio(c1));
        count_to_pulse(m);
        check("R4 new period after change", m, exp_ratio(c1));
    endtask

    task automatic t_reset_mid;
        int n;
        reset_with(3);
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 fref low after mid reset", int'(fref), 0);
        check("R1 ratio kept before code change", int'(ratio), 256);
        sel = 3'd5;
        @(negedge clk);
        check("R1 ratio tracks code in reset", int'(ratio), 1000);
        rst = 1'b0;
        count_to_pulse(n);
        check("R6 first pulse after mid reset", n, 1000);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++) t_code(c);
        t_mid_change(2, 0, 20);
        t_mid_change(0, 6, 3);
        t_mid_change(7, 1, 1000);
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule